// File: doc/BRIEF.md
# Ballot Tally and Feedback Controller

This block counts ballots for a small poll station. A one-hot selection input carries one switch per candidate and one switch for a "none of these" choice. An officer-controlled enable opens and closes the poll. While the poll is open, each clean press adds one vote to the chosen option's counter. The same press lights that option's acknowledge LED for a fixed number of clocks. A malformed press changes no counter and raises a one-clock reject pulse.

The per-option counters, their grand total and a leader report are all visible at the ports. When the enable is low, the leader report names the candidate with the most votes and flags a shared lead. A press is counted on its rising edge, so a switch that is held down counts once. A new ballot needs every switch released first.

Top module: `ballot_tally`

## Requirements
- R1: After reset every counter reads zero, all LEDs are off, the reject pulse is low and the total reads zero.
- R2: While `vote_en` is low, the selection input is ignored: no counter changes and `invalid_o` stays low.
- R3: With `vote_en` high, a selection that changes from all-zero to exactly one set bit adds one to that option's counter at the next clock edge. No other counter changes. Bit k (k = 0..3) selects candidate k, and bit 4 selects the "none of these" option.
- R4: Holding the same selection for many clocks counts one ballot. Another ballot is counted only after the input has been all-zero for at least one clock.
- R5: With `vote_en` high, a selection that changes to a non-zero pattern that is not a clean one-hot press raises `invalid_o` for exactly the following clock and changes no counter. This covers two or more bits set, and a change from a non-zero pattern.
- R6: Moving directly from one option's switch to another without releasing first is rejected as a repeated vote under R5.
- R7: Each 8-bit counter stops at 255. Further ballots for that option leave it at 255.
- R8: A counted ballot lights only that option's LED, starting with the clock edge that counts it, for exactly `LED_HOLD` clocks. A newer ballot reloads the hold time and moves the light to the new option. At most one LED is lit at a time.
- R9: `total_o` always equals the sum of all five counters and is 11 bits wide, so it cannot wrap.
- R10: While `vote_en` is low, `result_valid_o` is high and `winner_o` gives the index of the candidate with the highest count. The lowest index wins a shared lead, and `tie_o` is high when two or more candidates share the highest count. The "none of these" counter never wins. While `vote_en` is high, `result_valid_o`, `winner_o` and `tie_o` all read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| vote_en | input | 1 | Poll open when high |
| sel_i | input | 5 | Option switches, bits 0..3 candidates, bit 4 "none of these" |
| led_o | output | 5 | Acknowledge LEDs, one per option, same bit order as `sel_i` |
| invalid_o | output | 1 | One-clock reject pulse |
| tally_o | output | 40 | Counters; option k in bits 8k+7..8k |
| total_o | output | 11 | Sum of all counters |
| result_valid_o | output | 1 | Leader report valid (poll closed) |
| winner_o | output | 2 | Index of leading candidate |
| tie_o | output | 1 | Lead shared by two or more candidates |

## Verification
Corruption of the stored previous selection shows up first. A held switch is then recounted, or a fresh press is rejected, and `tally_o` or `invalid_o` differs at the first edge after the press. A wrong hold counter shows up as an LED that goes dark one clock early or stays lit one clock late. A wrong counter value shows up at once in `total_o` and, with the poll closed, in the leader report on the same cycle. The bench runs a behavioural model beside the design and compares every output on every clock, so each of these faults is reported in the cycle it becomes visible.

// File: rtl/ballot_pkg.sv
package ballot_pkg;

    // Outcome of looking at one clock's selection
    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_CAST   = 2'd1,
        EV_REJECT = 2'd2
    } ev_kind_e;

endpackage

// File: rtl/ballot_classify.sv
module ballot_classify
    import ballot_pkg::*;
#(
    parameter int N_OPT = 5,
    localparam int IDX_W = $clog2(N_OPT),
    localparam int ONES_W = $clog2(N_OPT + 1)
) (
    input  logic             vote_en,
    input  logic [N_OPT-1:0] sel,
    input  logic [N_OPT-1:0] prev,
    output ev_kind_e         kind,
    output logic [IDX_W-1:0] opt_idx
);

    logic [ONES_W-1:0] ones;

    always_comb begin
        ones    = '0;
        opt_idx = '0;
        for (int i = 0; i < N_OPT; i++) begin
            if (sel[i]) begin
                ones    = ones + 1'b1;
                opt_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        kind = EV_NONE;
        if (vote_en && (sel != '0) && (sel != prev)) begin
            if ((prev == '0) && (ones == ONES_W'(1))) begin
                kind = EV_CAST;
            end else begin
                kind = EV_REJECT;
            end
        end
    end

endmodule

// File: rtl/ballot_led_hold.sv
module ballot_led_hold #(
    parameter int N_OPT    = 5,
    parameter int LED_HOLD = 4,
    localparam int IDX_W = $clog2(N_OPT),
    localparam int TMR_W = $clog2(LED_HOLD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] opt_idx,
    output logic [N_OPT-1:0] led_o
);

    typedef struct packed {
        logic [TMR_W-1:0] tmr;
        logic [IDX_W-1:0] opt;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.tmr = TMR_W'(LED_HOLD);
            st_d.opt = opt_idx;
        end else if (st_q.tmr != '0) begin
            st_d.tmr = st_q.tmr - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        led_o = '0;
        if (st_q.tmr != '0) begin
            led_o[st_q.opt] = 1'b1;
        end
    end

    // R8: never more than one acknowledge light
    p_led_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(led_o));

    // R8: a counted ballot lights its own LED on the next cycle
    p_led_follows_cast_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> led_o[$past(opt_idx)]);

endmodule

// File: rtl/ballot_rank.sv
module ballot_rank #(
    parameter int N_CAND  = 4,
    parameter int COUNT_W = 8,
    localparam int IDX_W = $clog2(N_CAND)
) (
    input  logic [N_CAND-1:0][COUNT_W-1:0] cand_cnt,
    input  logic                           closed,
    output logic                           valid,
    output logic [IDX_W-1:0]               leader,
    output logic                           tie
);

    logic [COUNT_W-1:0]     best;
    logic [IDX_W-1:0]       best_idx;
    logic [$clog2(N_CAND+1)-1:0] n_best;

    always_comb begin
        best     = cand_cnt[0];
        best_idx = '0;
        for (int i = 1; i < N_CAND; i++) begin
            if (cand_cnt[i] > best) begin
                best     = cand_cnt[i];
                best_idx = IDX_W'(i);
            end
        end
        n_best = '0;
        for (int i = 0; i < N_CAND; i++) begin
            if (cand_cnt[i] == best) begin
                n_best = n_best + 1'b1;
            end
        end
    end

    always_comb begin
        valid  = closed;
        leader = closed ? best_idx : '0;
        tie    = closed && (n_best > 1);
    end

endmodule

// File: rtl/ballot_tally.sv
module ballot_tally
    import ballot_pkg::*;
#(
    parameter int N_CAND   = 4,
    parameter int COUNT_W  = 8,
    parameter int LED_HOLD = 4
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       vote_en,
    input  logic [N_CAND:0]                            sel_i,
    output logic [N_CAND:0]                            led_o,
    output logic                                       invalid_o,
    output logic [(N_CAND+1)*COUNT_W-1:0]              tally_o,
    output logic [COUNT_W+$clog2(N_CAND+1)-1:0]        total_o,
    output logic                                       result_valid_o,
    output logic [$clog2(N_CAND)-1:0]                  winner_o,
    output logic                                       tie_o
);

    localparam int N_OPT = N_CAND + 1;
    localparam int IDX_W = $clog2(N_OPT);
    localparam int TOT_W = COUNT_W + $clog2(N_OPT);

    typedef struct packed {
        logic [N_OPT-1:0]              prev;
        logic [N_OPT-1:0][COUNT_W-1:0] cnt;
        logic                          invalid;
    } tally_st_t;

    tally_st_t st_d, st_q;

    ev_kind_e         kind;
    logic [IDX_W-1:0] opt_idx;

    ballot_classify #(.N_OPT(N_OPT)) classify_i (
        .vote_en (vote_en),
        .sel     (sel_i),
        .prev    (st_q.prev),
        .kind    (kind),
        .opt_idx (opt_idx)
    );

    always_comb begin
        st_d         = st_q;
        st_d.prev    = sel_i;
        st_d.invalid = (kind == EV_REJECT);
        if ((kind == EV_CAST) && (st_q.cnt[opt_idx] != '1)) begin
            st_d.cnt[opt_idx] = st_q.cnt[opt_idx] + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    ballot_led_hold #(.N_OPT(N_OPT), .LED_HOLD(LED_HOLD)) led_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (kind == EV_CAST),
        .opt_idx (opt_idx),
        .led_o   (led_o)
    );

    logic [N_CAND-1:0][COUNT_W-1:0] cand_cnt;

    for (genvar g = 0; g < N_OPT; g++) begin : g_opt
        assign tally_o[g*COUNT_W +: COUNT_W] = st_q.cnt[g];

        // R7: a full counter stays full
        p_sat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (tally_o[g*COUNT_W +: COUNT_W] == '1) |=> (tally_o[g*COUNT_W +: COUNT_W] == '1));
    end

    for (genvar g = 0; g < N_CAND; g++) begin : g_cand
        assign cand_cnt[g] = st_q.cnt[g];

        // R10: no candidate outruns the reported leader
        p_leader_max_r10: assert property (@(posedge clk) disable iff (!rst_n)
            result_valid_o |-> (tally_o[winner_o*COUNT_W +: COUNT_W] >= tally_o[g*COUNT_W +: COUNT_W]));
    end

    logic [TOT_W-1:0] sum_v;

    always_comb begin
        sum_v = '0;
        for (int i = 0; i < N_OPT; i++) begin
            sum_v = sum_v + TOT_W'(st_q.cnt[i]);
        end
    end

    assign total_o   = sum_v;
    assign invalid_o = st_q.invalid;

    ballot_rank #(.N_CAND(N_CAND), .COUNT_W(COUNT_W)) rank_i (
        .cand_cnt (cand_cnt),
        .closed   (!vote_en),
        .valid    (result_valid_o),
        .leader   (winner_o),
        .tie      (tie_o)
    );

    // R2: closed poll freezes counters and raises no reject
    p_closed_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !vote_en |=> ($stable(tally_o) && !invalid_o));

    // R5: a rejected press leaves every counter untouched
    p_reject_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_o |-> $stable(tally_o));

    // R3: at most one vote is added per clock
    p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((total_o == $past(total_o)) || (total_o == $past(total_o) + 1'b1)));

    // R5: a reject pulse lasts one clock unless a new bad press follows
    p_reject_needs_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (invalid_o && $stable(sel_i)) |=> !invalid_o);

endmodule

// File: tb/ballot_tally_tb.sv
`timescale 1ns/1ps
module ballot_tally_tb_top;

    localparam int HOLD = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vote_en = 1'b0;
    logic [4:0]  sel = '0;
    logic [4:0]  led;
    logic        invalid;
    logic [39:0] tally;
    logic [10:0] total;
    logic        rvalid;
    logic [1:0]  winner;
    logic        tie;

    always #4 clk = ~clk;

    ballot_tally #(.N_CAND(4), .COUNT_W(8), .LED_HOLD(HOLD)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .vote_en        (vote_en),
        .sel_i          (sel),
        .led_o          (led),
        .invalid_o      (invalid),
        .tally_o        (tally),
        .total_o        (total),
        .result_valid_o (rvalid),
        .winner_o       (winner),
        .tie_o          (tie)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    int m_cnt[5];
    int m_prev;
    int m_opt;
    int m_tmr;
    int m_inv;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int cnt_of(input int k);
        return int'(tally[8*k +: 8]);
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 5; k++) m_cnt[k] = 0;
        m_prev = 0; m_opt = 0; m_tmr = 0; m_inv = 0;
    endtask

    task automatic model_clock(input bit en, input int s);
        bit fresh;
        bit good;
        int k;
        fresh = en && (s != 0) && (s != m_prev);
        good  = fresh && (m_prev == 0) && ($countones(s[4:0]) == 1);
        m_inv = fresh && !good;
        if (good) begin
            k = 0;
            for (int i = 0; i < 5; i++) if (s[i]) k = i;
            if (m_cnt[k] < 255) m_cnt[k]++;
            m_opt = k;
            m_tmr = HOLD;
        end else if (m_tmr > 0) begin
            m_tmr--;
        end
        m_prev = s;
    endtask

    task automatic compare_all();
        int sum;
        int best;
        int bidx;
        int nb;
        sum = 0;
        for (int k = 0; k < 5; k++) begin
            chk("R3", "counter", cnt_of(k), m_cnt[k]);
            sum += m_cnt[k];
        end
        chk("R8", "leds", int'(led), (m_tmr > 0) ? (1 << m_opt) : 0);
        chk("R5", "invalid", int'(invalid), m_inv);
        chk("R9", "total", int'(total), sum);
        best = m_cnt[0]; bidx = 0; nb = 0;
        for (int k = 1; k < 4; k++) if (m_cnt[k] > best) begin best = m_cnt[k]; bidx = k; end
        for (int k = 0; k < 4; k++) if (m_cnt[k] == best) nb++;
        chk("R10", "result_valid", int'(rvalid), vote_en ? 0 : 1);
        chk("R10", "winner", int'(winner), vote_en ? 0 : bidx);
        chk("R10", "tie", int'(tie), (!vote_en && nb > 1) ? 1 : 0);
    endtask

    task automatic step(input bit en, input logic [4:0] s);
        vote_en = en;
        sel = s;
        @(posedge clk);
        if (rst_n) model_clock(en, int'(s));
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        vote_en = 1'b0;
        sel = '0;
        repeat (3) @(negedge clk);
        model_reset();
        rst_n = 1'b1;
        // R1: state straight after reset
        chk("R1", "total after reset", int'(total), 0);
        chk("R1", "leds after reset", int'(led), 0);
        chk("R1", "invalid after reset", int'(invalid), 0);
        chk("R1", "tally after reset", (tally == '0) ? 1 : 0, 1);
    endtask

    task automatic cast(input logic [4:0] s);
        step(1'b1, s);
        step(1'b1, 5'b00000);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        step(1'b0, 5'b00000);

        // R2: presses with the poll closed
        step(1'b0, 5'b00001);
        step(1'b0, 5'b00011);
        chk("R2", "candidate0 while closed", cnt_of(0), 0);
        chk("R2", "invalid while closed", int'(invalid), 0);
        step(1'b0, 5'b00000);

        // R4: hold candidate 2 for several clocks
        step(1'b1, 5'b00100);
        chk("R8", "led on first cycle", int'(led), 5'b00100);
        step(1'b1, 5'b00100);
        step(1'b1, 5'b00100);
        step(1'b1, 5'b00100);
        chk("R4", "held press counted once", cnt_of(2), 1);
        step(1'b1, 5'b00000);
        chk("R8", "led off after hold", int'(led), 0);
        step(1'b1, 5'b00100);
        chk("R4", "second press after release", cnt_of(2), 2);
        step(1'b1, 5'b00000);

        // R5: multi-switch pattern
        step(1'b1, 5'b00011);
        chk("R5", "reject pulse", int'(invalid), 1);
        step(1'b1, 5'b00011);
        chk("R5", "pulse one clock", int'(invalid), 0);
        step(1'b1, 5'b00000);

        // R6: slide from candidate 1 to candidate 3
        step(1'b1, 5'b00010);
        step(1'b1, 5'b01000);
        chk("R6", "slide rejected", int'(invalid), 1);
        chk("R6", "candidate3 unchanged", cnt_of(3), 0);
        step(1'b1, 5'b00000);

        // R8: reload by a newer ballot while lit
        step(1'b1, 5'b10000);
        step(1'b1, 5'b00000);
        step(1'b1, 5'b01000);
        chk("R8", "light moved", int'(led), 5'b01000);
        for (int i = 0; i < HOLD + 2; i++) step(1'b1, 5'b00000);

        // R7: saturate candidate 0
        for (int i = 0; i < 260; i++) cast(5'b00001);
        chk("R7", "counter stops at 255", cnt_of(0), 255);

        // R10: closed poll reports candidate 0
        step(1'b0, 5'b00000);
        chk("R10", "leader after saturation", int'(winner), 0);
        chk("R10", "no tie", int'(tie), 0);

        // R10: shared lead, "none of these" excluded
        do_reset();
        cast(5'b00010); cast(5'b00010);
        cast(5'b01000); cast(5'b01000);
        cast(5'b00001);
        for (int i = 0; i < 5; i++) cast(5'b10000);
        step(1'b1, 5'b00000);
        chk("R10", "open poll hides result", int'(rvalid), 0);
        step(1'b0, 5'b00000);
        chk("R10", "tie lowest index", int'(winner), 1);
        chk("R10", "tie flag", int'(tie), 1);
        chk("R9", "total with tie", int'(total), 10);

        // R10: single clear leader
        cast(5'b01000);
        step(1'b0, 5'b00000);
        chk("R10", "clear leader", int'(winner), 3);
        chk("R10", "clear leader no tie", int'(tie), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule